// File: doc/BRIEF.md
# Nine/Eighteen Bit Port Width Bridge

This block sits between a pair of external streaming ports and a FIFO core whose storage words are always 18 bits wide. Each external port, the write side and the read side, can work on full 18-bit words or on 9-bit halves (typically a byte plus a parity bit). The two widths are chosen independently, so a stream written in halves can be read as words, and the other way round. Every port uses a valid/ready handshake, and a transfer happens on a rising clock edge where both are high.

On a narrow write port the bridge holds the first half in a register and writes one storage word to the core only when the second half arrives. On a narrow read port it presents each core word as two consecutive halves and pops the word only when the second half is taken. A byte-order select decides whether the first half of a pair maps to the upper half of the word (bits 17:9) or to the lower half (bits 8:0). All three selects are sampled while the synchronous active-high reset is asserted. Storage, occupancy flags and clock crossing belong to the core.

Top module: `width_bridge`

## Requirements
- R1: The selects `in_wide_sel`, `out_wide_sel` and `big_end_sel` are sampled on every clock edge while `rst` is high. Changing them while `rst` is low has no effect on behaviour.
- R2: With a select high (18-bit), that side passes whole words. `core_wr_data` equals `in_data` and `out_data` equals `core_rd_data`, and each handshake maps to exactly one core transfer.
- R3: With narrow input (`in_wide_sel`=0), the first half of a pair is accepted without waiting for `core_wr_ready`. While only one half is held, `core_wr_valid` stays low, so a lone half never reaches the core.
- R4: With narrow input, the second half is accepted only together with a core write. The write carries both halves and is followed by a cycle with `core_wr_valid` low.
- R5: In big-endian mode (`big_end_sel`=1) the first half of a pair occupies word bits 17:9. In little-endian mode it occupies bits 8:0. This holds for packing on the write side and unpacking on the read side.
- R6: With narrow output (`out_wide_sel`=0), each core word yields two output beats, and `core_rd_ready` is raised only during the second beat.
- R7: With narrow output, the half is placed on `out_data[8:0]` and `out_data[17:9]` reads zero.
- R8: Reset discards a half held from before the reset. The first half accepted after reset starts a new pair.
- R9: While `rst` is high, `in_ready`, `core_wr_valid`, `out_valid` and `core_rd_ready` are all low.
- R10: While `out_valid` is high and `out_ready` is low, `out_data` keeps its value into the next cycle, provided the core holds its word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; selects are sampled during it |
| in_wide_sel | input | 1 | 1 = 18-bit write port, 0 = 9-bit write port |
| out_wide_sel | input | 1 | 1 = 18-bit read port, 0 = 9-bit read port |
| big_end_sel | input | 1 | 1 = first half is bits 17:9, 0 = first half is bits 8:0 |
| in_valid | input | 1 | Write port data valid |
| in_ready | output | 1 | Write port can accept |
| in_data | input | 18 | Write data; bits 8:0 used in 9-bit mode |
| core_wr_valid | output | 1 | Storage word offered to the core |
| core_wr_ready | input | 1 | Core accepts a word |
| core_wr_data | output | 18 | Storage word to the core |
| core_rd_valid | input | 1 | Core presents a word |
| core_rd_ready | output | 1 | Bridge pops the core word |
| core_rd_data | input | 18 | Storage word from the core |
| out_valid | output | 1 | Read port data valid |
| out_ready | input | 1 | Read port consumer accepts |
| out_data | output | 18 | Read data; bits 8:0 only in 9-bit mode |

## Verification
On every cycle, the embedded properties check the pairing discipline. A held half only appears after an accepted beat. A packed core write is always followed by an idle write cycle. A core pop returns the read side to its first-half phase. A stalled output keeps its phase, and the sampled configuration stays fixed outside reset. The placement of halves under each byte order, the zeroed upper bits, the discarding of a half across reset and the indifference to select changes after reset only show up as data values. The bench shows them by sweeping all eight width and order combinations with ready patterns on both sides.

// File: rtl/width_bridge_pkg.sv
package width_bridge_pkg;

    localparam int HALF_W = 9;
    localparam int WORD_W = 2 * HALF_W;

    typedef logic [HALF_W-1:0] half_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic in_wide;
        logic out_wide;
        logic big_end;
    } bridge_cfg_t;

    // Place an ordered pair of halves into a storage word.
    function automatic word_t join_halves(half_t first, half_t second, logic big_end);
        return big_end ? {first, second} : {second, first};
    endfunction

    // Select the half sent in a given phase (0 = first, 1 = second).
    function automatic half_t pick_half(word_t w, logic phase, logic big_end);
        logic upper;
        upper = big_end ^ phase;
        return upper ? w[WORD_W-1:HALF_W] : w[HALF_W-1:0];
    endfunction

endpackage

// File: rtl/wb_pack.sv
module wb_pack
    import width_bridge_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  bridge_cfg_t cfg,
    input  logic        in_valid,
    output logic        in_ready,
    input  word_t       in_data,
    output logic        wr_valid,
    input  logic        wr_ready,
    output word_t       wr_data
);

    logic  have_half;
    half_t held_half;

    always_comb begin
        wr_data  = in_data;
        wr_valid = 1'b0;
        in_ready = 1'b0;
        if (!rst) begin
            if (cfg.in_wide) begin
                wr_valid = in_valid;
                in_ready = wr_ready;
            end else if (!have_half) begin
                in_ready = 1'b1;
            end else begin
                wr_valid = in_valid;
                in_ready = wr_ready;
                wr_data  = join_halves(held_half, in_data[HALF_W-1:0], cfg.big_end);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            have_half <= 1'b0;
            held_half <= '0;
        end else if (!cfg.in_wide && in_valid && in_ready) begin
            if (!have_half) begin
                held_half <= in_data[HALF_W-1:0];
                have_half <= 1'b1;
            end else begin
                have_half <= 1'b0;
            end
        end
    end

    // R3: a held half only appears after an accepted beat
    p_half_from_accept_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(have_half) |-> $past(in_valid && in_ready));

    // R4: a packed write empties the holding register
    p_pair_spacing_r4: assert property (@(posedge clk) disable iff (rst)
        (!cfg.in_wide && wr_valid && wr_ready) |=> !wr_valid);

endmodule

// File: rtl/wb_unpack.sv
module wb_unpack
    import width_bridge_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  bridge_cfg_t cfg,
    input  logic        rd_valid,
    output logic        rd_ready,
    input  word_t       rd_data,
    output logic        out_valid,
    input  logic        out_ready,
    output word_t       out_data
);

    logic phase;

    always_comb begin
        out_valid = !rst && rd_valid;
        rd_ready  = 1'b0;
        out_data  = rd_data;
        if (!cfg.out_wide) begin
            out_data = {{HALF_W{1'b0}}, pick_half(rd_data, phase, cfg.big_end)};
        end
        if (!rst) begin
            rd_ready = cfg.out_wide ? out_ready : (out_ready && phase);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= 1'b0;
        end else if (!cfg.out_wide && out_valid && out_ready) begin
            phase <= ~phase;
        end
    end

    // R6: popping a core word returns to the first-half phase
    p_pop_restarts_r6: assert property (@(posedge clk) disable iff (rst)
        (!cfg.out_wide && rd_valid && rd_ready) |=> !phase);

    // R10: a stalled beat keeps its phase
    p_stall_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> $stable(phase));

endmodule

// File: rtl/width_bridge.sv
module width_bridge
    import width_bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_wide_sel,
    input  logic              out_wide_sel,
    input  logic              big_end_sel,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_data,
    output logic              core_wr_valid,
    input  logic              core_wr_ready,
    output logic [WORD_W-1:0] core_wr_data,
    input  logic              core_rd_valid,
    output logic              core_rd_ready,
    input  logic [WORD_W-1:0] core_rd_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data
);

    bridge_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '{in_wide: in_wide_sel, out_wide: out_wide_sel, big_end: big_end_sel};
        end
    end

    wb_pack u_pack (
        .clk      (clk),
        .rst      (rst),
        .cfg      (cfg_q),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_data  (in_data),
        .wr_valid (core_wr_valid),
        .wr_ready (core_wr_ready),
        .wr_data  (core_wr_data)
    );

    wb_unpack u_unpack (
        .clk       (clk),
        .rst       (rst),
        .cfg       (cfg_q),
        .rd_valid  (core_rd_valid),
        .rd_ready  (core_rd_ready),
        .rd_data   (core_rd_data),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data)
    );

    // R1: configuration is frozen outside reset
    p_cfg_locked_r1: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $stable(cfg_q));

endmodule

// File: tb/width_bridge_bench.sv
`timescale 1ns/1ps
module width_bridge_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_wide_sel = 1'b0, out_wide_sel = 1'b0, big_end_sel = 1'b0;
    logic        in_valid = 1'b0, core_wr_ready = 1'b0, core_rd_valid = 1'b0, out_ready = 1'b0;
    logic [17:0] in_data = '0, core_rd_data = '0;
    logic        in_ready, core_wr_valid, core_rd_ready, out_valid;
    logic [17:0] core_wr_data, out_data;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    width_bridge u_width_bridge (
        .clk(clk), .rst(rst),
        .in_wide_sel(in_wide_sel), .out_wide_sel(out_wide_sel), .big_end_sel(big_end_sel),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .core_wr_valid(core_wr_valid), .core_wr_ready(core_wr_ready), .core_wr_data(core_wr_data),
        .core_rd_valid(core_rd_valid), .core_rd_ready(core_rd_ready), .core_rd_data(core_rd_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    task automatic check(input string req, input logic [17:0] act, input logic [17:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [8:0] half_in(int c, int i);
        return 9'((i * 37 + c * 5 + 3) & 9'h1FF);
    endfunction
    function automatic logic [17:0] word_in(int c, int i);
        return 18'((i * 1234 + c * 77 + 5) & 18'h3FFFF);
    endfunction
    function automatic logic [17:0] word_rd(int c, int k);
        return 18'((k * 2221 + c * 91 + 17) & 18'h3FFFF);
    endfunction
    function automatic logic [17:0] exp_wr(int c, int k);
        logic [8:0] f, s;
        if (c[2]) return word_in(c, k);
        f = half_in(c, 2 * k);
        s = half_in(c, 2 * k + 1);
        return c[0] ? {f, s} : {s, f};   // R5
    endfunction
    function automatic logic [17:0] exp_out(int c, int j);
        logic [17:0] w;
        logic upper;
        if (c[1]) return word_rd(c, j);
        w = word_rd(c, j / 2);
        upper = c[0] ^ (j % 2 == 1);
        return {9'b0, upper ? w[17:9] : w[8:0]};
    endfunction

    task automatic do_reset(input int c);
        @(negedge clk);
        rst = 1'b1;
        in_wide_sel = c[2]; out_wide_sel = c[1]; big_end_sel = c[0];
        in_valid = 1'b1; core_wr_ready = 1'b1; core_rd_valid = 1'b1; out_ready = 1'b1;
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            #1;
            check("R9 in_ready in reset", {17'b0, in_ready}, 18'd0);
            check("R9 core_wr_valid in reset", {17'b0, core_wr_valid}, 18'd0);
            check("R9 out_valid in reset", {17'b0, out_valid}, 18'd0);
            check("R9 core_rd_ready in reset", {17'b0, core_rd_ready}, 18'd0);
        end
        rst = 1'b0;
        in_valid = 1'b0; core_rd_valid = 1'b0;
        // R1: flip selects after reset; behaviour must not follow
        in_wide_sel = ~c[2]; out_wide_sel = ~c[1]; big_end_sel = ~c[0];
    endtask

    task automatic run_cfg(input int c);
        int nbeats, nout, wi, wc, rw, ob;
        logic prev_stall;
        logic [17:0] prev_out;
        nbeats = c[2] ? 4 : 8;
        nout   = c[1] ? 4 : 8;
        wi = 0; wc = 0; rw = 0; ob = 0;
        prev_stall = 1'b0; prev_out = '0;
        do_reset(c);
        if (!c[2]) begin
            // R8: leave a stray half behind, then reset again
            @(negedge clk);
            in_valid = 1'b1; in_data = 18'h00155; #1;
            check("R3 first half accepted", {17'b0, in_ready}, 18'd1);
            @(negedge clk);
            in_valid = 1'b0;
            do_reset(c);
        end
        for (int cyc = 0; cyc < 200; cyc++) begin
            if (wi == nbeats && wc == 4 && ob == nout) break;
            @(negedge clk);
            in_valid      = (wi < nbeats);
            in_data       = c[2] ? word_in(c, wi) : {9'h1AA, half_in(c, wi)};
            core_wr_ready = (cyc % 3 != 1);
            core_rd_valid = (rw < 4);
            core_rd_data  = word_rd(c, rw);
            out_ready     = (cyc % 4 != 2);
            #1;
            if (prev_stall)
                check("R10 stalled out_data held", out_data, prev_out);
            prev_stall = out_valid && !out_ready;
            prev_out   = out_data;
            if (!c[2] && (wi % 2 == 0))
                check("R3 lone half hidden", {17'b0, core_wr_valid}, 18'd0);
            if (!c[1] && core_rd_ready)
                check("R6 pop only on second beat", {17'b0, ob[0]}, 18'd1);
            if (core_wr_valid && core_wr_ready) begin
                check(c[2] ? "R2 wide write word" : "R4 R5 R8 packed word", core_wr_data, exp_wr(c, wc));
                wc++;
            end
            if (out_valid && out_ready) begin
                if (!c[1]) check("R7 upper bits zero", {9'b0, out_data[17:9]}, 18'd0);
                check(c[1] ? "R2 wide read word" : "R5 R6 half order", out_data, exp_out(c, ob));
                ob++;
            end
            if (in_valid && in_ready) wi++;
            if (core_rd_valid && core_rd_ready) rw++;
        end
        check("R4 core write count", 18'(wc), 18'd4);
        check("R6 output beat count", 18'(ob), 18'(nout));
        in_valid = 1'b0; core_rd_valid = 1'b0;
    endtask

    initial begin
        for (int c = 0; c < 8; c++) run_cfg(c);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #100000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule